// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address into a real address by searching a page table held in memory. The caller presents the address, the 24-bit segment identifier taken from the segment descriptor, and whether the access is a store, then pulses `start`. The walker forms a hash of the segment identifier and the page index. It reads up to eight entries of the primary group and, if none of them matches, up to eight entries of the secondary group selected by the complemented hash.

On a hit it reports both words of the matching entry and the real address. Before it finishes, it sets the referenced and changed flags in memory with single-byte writes. If both groups miss, it reports a miss. Permission checking belongs to the caller.

The walker masters a simple memory port. The port carries one request at a time, either a 32-bit word read or a byte write, and each request is held until it is acknowledged. Memory is big-endian: byte offset 0 of a word is bits 31:24. The table base and table mask come from configuration inputs and are sampled at `start`.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `hit`, `miss` and `mem_req` are all low.
- R2: The page index is ea[27:12] (16 bits). The primary hash is the zero-extended segment identifier XOR the page index. The group address is base + ((hash << 6) AND mask). The base must be 64-byte aligned and mask bits 5:0 must be zero.
- R3: Entries of a group are visited in order 0..7, entry k at group + 8k. For each entry, the first word (offset 0) is read, and the second word (offset 4) is read only when the first word matches. Only one request is outstanding at a time.
- R4: A first word matches when bit 31 (valid) is 1, bit 6 equals the pass (0 primary, 1 secondary), bits 30:7 equal the segment identifier, and bits 5:0 equal ea[27:22].
- R5: When all eight primary entries fail, the same scan is repeated on the group chosen by the bitwise complement of the primary hash, with bit 6 required to be 1.
- R6: On a hit, `done` and `hit` are high for exactly one cycle. `pte_w0` and `pte_w1` hold the two words as read, and `real_addr` = {second word[31:12], ea[11:0]}.
- R7: When second-word bit 8 (referenced) is 0, a byte write goes to entry offset 6 with data second word[15:8] OR 0x01.
- R8: When second-word bit 7 (changed) is 0 and the access is a store, a byte write goes to entry offset 7 with data second word[7:0] OR 0x80. It follows any R7 write. Loads never write this byte.
- R9: When both groups miss after 16 first-word reads, `done` and `miss` are high for one cycle and no write is issued.
- R10: `busy` is high from the cycle after `start` is accepted until the `done` cycle, where it is low. `start` is ignored while busy. `mem_req` holds its address, direction and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| ea | input | 32 | Effective address |
| vsid | input | 24 | Segment identifier from the segment descriptor |
| is_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Page table base address |
| tbl_mask | input | 32 | Page table group offset mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Completion with a matching entry |
| miss | output | 1 | Completion with no matching entry |
| pte_w0 | output | 32 | First word of the matching entry |
| pte_w1 | output | 32 | Second word of the matching entry, as read |
| real_addr | output | 32 | Translated real address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a byte write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read word |

## Verification
A wrong entry index, pass flag or group address shows at once as a memory request to an address the reference walk did not predict, on the very access where the divergence begins. A faulty match decision appears either as a missing second-word read or as an extra one, and later as a wrong hit, miss or entry word at the `done` pulse. Flag write-back mistakes surface as a missing, extra or wrongly valued byte write before `done`. A stuck state machine surfaces as `busy` failing to fall within the expected number of accesses.

// File: rtl/hpt_pkg.sv
// Shared types for the hashed page table walker.
// Assumes: nothing beyond the walker's own parameters.
package hpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TAG,
        ST_RD_DATA,
        ST_SET_REF,
        ST_SET_CHG,
        ST_FIN
    } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
// Group address and compare tag generation.
// Forms the page index from the address bits below the segment boundary,
// XORs it with the segment identifier, complements for the secondary pass,
// scales by the group size, masks and adds the table base.
// Assumes: base is group-aligned and mask has its group-offset bits clear.
module hpt_hash #(
    parameter int AW        = 32,
    parameter int VSID_W    = 24,
    parameter int PAGE_BITS = 12,
    parameter int SEG_BITS  = 28,
    parameter int API_W     = 6,
    parameter int GRP_SHIFT = 6
) (
    input  logic [AW-1:0]           ea,
    input  logic [VSID_W-1:0]       vsid,
    input  logic                    pass,
    input  logic [AW-1:0]           base,
    input  logic [AW-1:0]           mask,
    output logic [AW-1:0]           group_base,
    output logic [VSID_W+API_W-1:0] cmp_tag
);
    localparam int PIDX_W = SEG_BITS - PAGE_BITS;

    logic [PIDX_W-1:0] pidx;
    logic [AW-1:0]     hash_p;
    logic [AW-1:0]     hash_sel;

    // Hash selection and group address for the current pass.
    always_comb begin
        pidx       = ea[SEG_BITS-1:PAGE_BITS];
        hash_p     = AW'(vsid) ^ AW'(pidx);
        hash_sel   = pass ? ~hash_p : hash_p;
        group_base = base + ((hash_sel << GRP_SHIFT) & mask);
        cmp_tag    = {vsid, pidx[PIDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hpt_match.sv
// Entry first-word matcher.
// Checks the valid flag, the hash-pass flag and the segment/page tag.
// Assumes: first word layout valid | vsid | pass flag | abbreviated index.
module hpt_match #(
    parameter int AW     = 32,
    parameter int VSID_W = 24,
    parameter int API_W  = 6
) (
    input  logic [AW-1:0]           word0,
    input  logic                    pass,
    input  logic [VSID_W+API_W-1:0] cmp_tag,
    output logic                    match
);
    // Match decision for one entry.
    always_comb begin
        match = word0[AW-1]
             && (word0[API_W] == pass)
             && ({word0[AW-2:API_W+1], word0[API_W-1:0]} == cmp_tag);
    end
endmodule

// File: rtl/hpt_walker.sv
// Hashed page table walker (top).
// Scans the primary group, then the secondary group, one memory request at
// a time; on a hit writes back referenced/changed bytes and pulses done.
// Assumes: memory acknowledges each request once, read data valid with ack;
// big-endian byte numbering within a word.
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int AW            = 32,
    parameter int VSID_W        = 24,
    parameter int GROUP_ENTRIES = 8,
    parameter int PAGE_BITS     = 12,
    parameter int SEG_BITS      = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     ea,
    input  logic [VSID_W-1:0] vsid,
    input  logic              is_store,
    input  logic [AW-1:0]     tbl_base,
    input  logic [AW-1:0]     tbl_mask,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              miss,
    output logic [AW-1:0]     pte_w0,
    output logic [AW-1:0]     pte_w1,
    output logic [AW-1:0]     real_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [AW-1:0]     mem_rdata
);
    localparam int WORD_BYTES  = AW / 8;
    localparam int ENTRY_BYTES = 2 * WORD_BYTES;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int GRP_SHIFT   = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
    localparam int IDX_W       = $clog2(GROUP_ENTRIES);
    localparam int API_W       = AW - VSID_W - 2;
    localparam int REF_BIT     = 8;
    localparam int CHG_BIT     = 7;
    localparam int REF_OFF     = ENTRY_BYTES - 2;
    localparam int CHG_OFF     = ENTRY_BYTES - 1;

    walk_state_t              st;
    logic                     pass_q;
    logic [IDX_W-1:0]         idx_q;
    logic [AW-1:0]            ea_q, base_q, mask_q, w0_q, w1_q;
    logic [VSID_W-1:0]        vsid_q;
    logic                     store_q, hit_q;
    logic [AW-1:0]            group_base, entry_base;
    logic [VSID_W+API_W-1:0]  cmp_tag;
    logic                     tag_hit, last_idx;

    hpt_hash #(
        .AW(AW), .VSID_W(VSID_W), .PAGE_BITS(PAGE_BITS),
        .SEG_BITS(SEG_BITS), .API_W(API_W), .GRP_SHIFT(GRP_SHIFT)
    ) u_hash (
        .ea(ea_q), .vsid(vsid_q), .pass(pass_q), .base(base_q),
        .mask(mask_q), .group_base(group_base), .cmp_tag(cmp_tag)
    );

    hpt_match #(.AW(AW), .VSID_W(VSID_W), .API_W(API_W)) u_match (
        .word0(mem_rdata), .pass(pass_q), .cmp_tag(cmp_tag), .match(tag_hit)
    );

    // Entry address and end-of-group detection.
    always_comb begin
        entry_base = group_base + (AW'(idx_q) << ENTRY_SHIFT);
        last_idx   = (idx_q == IDX_W'(GROUP_ENTRIES - 1));
    end

    // Memory request generation from the walk state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_base;
        mem_wdata = 8'h00;
        unique case (st)
            ST_RD_TAG:  mem_req = 1'b1;
            ST_RD_DATA: begin
                mem_req  = 1'b1;
                mem_addr = entry_base + AW'(WORD_BYTES);
            end
            ST_SET_REF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = entry_base + AW'(REF_OFF);
                mem_wdata = w1_q[REF_BIT +: 8] | 8'h01;
            end
            ST_SET_CHG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = entry_base + AW'(CHG_OFF);
                mem_wdata = w1_q[7:0] | 8'h80;
            end
            default: ;
        endcase
    end

    // Walk sequencing: scan, switch pass, write back flags, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            ea_q    <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            vsid_q  <= '0;
            store_q <= 1'b0;
            w0_q    <= '0;
            w1_q    <= '0;
            hit_q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    ea_q    <= ea;
                    vsid_q  <= vsid;
                    store_q <= is_store;
                    base_q  <= tbl_base;
                    mask_q  <= tbl_mask;
                    pass_q  <= 1'b0;
                    idx_q   <= '0;
                    hit_q   <= 1'b0;
                    st      <= ST_RD_TAG;
                end
                ST_RD_TAG: if (mem_ack) begin
                    w0_q <= mem_rdata;
                    if (tag_hit) begin
                        st <= ST_RD_DATA;
                    end else if (last_idx) begin
                        if (pass_q) begin
                            st <= ST_FIN;
                        end else begin
                            pass_q <= 1'b1;
                            idx_q  <= '0;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_RD_DATA: if (mem_ack) begin
                    w1_q  <= mem_rdata;
                    hit_q <= 1'b1;
                    if (!mem_rdata[REF_BIT])
                        st <= ST_SET_REF;
                    else if (!mem_rdata[CHG_BIT] && store_q)
                        st <= ST_SET_CHG;
                    else
                        st <= ST_FIN;
                end
                ST_SET_REF: if (mem_ack) begin
                    st <= (!w1_q[CHG_BIT] && store_q) ? ST_SET_CHG : ST_FIN;
                end
                ST_SET_CHG: if (mem_ack) st <= ST_FIN;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Result outputs.
    always_comb begin
        busy      = (st != ST_IDLE) && (st != ST_FIN);
        done      = (st == ST_FIN);
        hit       = done && hit_q;
        miss      = done && !hit_q;
        pte_w0    = w0_q;
        pte_w1    = w1_q;
        real_addr = {w1_q[AW-1:PAGE_BITS], ea_q[PAGE_BITS-1:0]};
    end
endmodule

// File: rtl/hpt_walker_chk.sv
// Protocol checker for the page table walker, bound to every instance.
// Assumes: table base group-aligned so entry byte offsets appear in addr[2:0].
module hpt_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata
);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_req_in_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));

    assert_ref_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[2:0] == 3'd6) |-> mem_wdata[0]);

    assert_chg_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[2:0] == 3'd7) |-> mem_wdata[7]);
endmodule

bind hpt_walker hpt_walker_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ea = '0;
    logic [23:0] vsid = '0;
    logic        is_store = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [31:0] tbl_mask = '0;
    logic        busy, done, hit, miss;
    logic [31:0] pte_w0, pte_w1, real_addr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [logic [31:0]];
    logic        q_we   [$];
    logic [31:0] q_addr [$];
    logic [7:0]  q_wd   [$];
    logic        e_hit;
    logic [31:0] e_w0, e_w1, e_ra;

    always #10 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .vsid(vsid),
        .is_store(is_store), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .busy(busy), .done(done), .hit(hit), .miss(miss),
        .pte_w0(pte_w0), .pte_w1(pte_w1), .real_addr(real_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
    endfunction

    function automatic logic [31:0] gbase(input logic [31:0] e, input logic [23:0] v,
                                          input int p, input logic [31:0] b, input logic [31:0] m);
        logic [31:0] h;
        h = {8'h0, v} ^ {16'h0, e[27:12]};
        if (p != 0) h = ~h;
        return b + ((h << 6) & m);
    endfunction

    function automatic logic [31:0] mk_w0(input logic v, input logic [23:0] s,
                                          input logic h, input logic [31:0] e);
        return {v, s, h, e[27:22]};
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a >> 2]       = w0;
        mem[(a + 4) >> 2] = w1;
    endtask

    // Memory responder: one-cycle ack, applies byte writes, checks each access.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= rd(mem_addr);
            if (mem_we) begin
                int sh;
                logic [31:0] w;
                sh = (3 - int'(mem_addr[1:0])) * 8;
                w  = rd(mem_addr);
                w  = (w & ~(32'hFF << sh)) | (32'(mem_wdata) << sh);
                mem[mem_addr >> 2] = w;
            end
            if (q_addr.size() == 0) begin
                tests++; fails++;
                $display("FAIL R3: actual unexpected access %0h expected none", mem_addr);
            end else begin
                string tg;
                tg = !q_we[0] ? "R3 access" : (q_addr[0][0] ? "R8 changed write" : "R7 referenced write");
                check(tg, {mem_we, mem_addr, mem_we ? mem_wdata : 8'h00},
                          {q_we[0], q_addr[0], q_wd[0]});
                void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_wd.pop_front());
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Behavioural reference walk: fills the expected access queue and result.
    task automatic model(input logic [31:0] e, input logic [23:0] v, input logic s,
                         input logic [31:0] b, input logic [31:0] m);
        e_hit = 1'b0;
        for (int p = 0; p < 2 && !e_hit; p++) begin
            for (int i = 0; i < 8 && !e_hit; i++) begin
                logic [31:0] a, w0, w1;
                a  = gbase(e, v, p, b, m) + 32'(i * 8);
                w0 = rd(a);
                q_we.push_back(1'b0); q_addr.push_back(a); q_wd.push_back(8'h0);
                if (w0[31] && w0[6] == p[0] && w0[30:7] == v && w0[5:0] == e[27:22]) begin
                    w1 = rd(a + 4);
                    q_we.push_back(1'b0); q_addr.push_back(a + 4); q_wd.push_back(8'h0);
                    e_hit = 1'b1; e_w0 = w0; e_w1 = w1; e_ra = {w1[31:12], e[11:0]};
                    if (!w1[8]) begin
                        q_we.push_back(1'b1); q_addr.push_back(a + 6); q_wd.push_back(w1[15:8] | 8'h01);
                    end
                    if (!w1[7] && s) begin
                        q_we.push_back(1'b1); q_addr.push_back(a + 7); q_wd.push_back(w1[7:0] | 8'h80);
                    end
                end
            end
        end
    endtask

    task automatic walk(input string name, input logic [31:0] e, input logic [23:0] v,
                        input logic s, input logic [31:0] b, input logic [31:0] m,
                        input bit poke);
        int cyc;
        bit busy_bad;
        model(e, v, s, b, m);
        @(negedge clk);
        ea = e; vsid = v; is_store = s; tbl_base = b; tbl_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; busy_bad = 0;
        while (!done && cyc < 2000) begin
            if (!busy) busy_bad = 1;
            if (poke && cyc == 5) begin
                start = 1'b1; ea = e ^ 32'h0550_0000; is_store = ~s;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        $display("[TB] walk %s", name);
        check("R10 busy through walk", busy_bad, 0);
        check("R10 busy low at done", busy, 0);
        check("R9 done reached", done, 1);
        check(e_hit ? "R6 hit flag" : "R9 miss flag", {hit, miss}, {e_hit, !e_hit});
        if (e_hit) begin
            check("R6 entry words", {pte_w0, pte_w1}, {e_w0, e_w1});
            check("R6 real address", real_addr, e_ra);
        end
        check("R3 all expected accesses made", q_addr.size(), 0);
        q_we.delete(); q_addr.delete(); q_wd.delete();
        @(negedge clk);
        check("R6 done one cycle", {done, hit, miss}, 0);
        if (poke) check("R10 start ignored while busy", busy, 0);
    endtask

    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [31:0] MASK = 32'h0000_FFC0;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] e, g, g2;
        logic [23:0] v;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy, done, hit, miss, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {busy, done, mem_req}, 0);

        // R2 R4: primary hit at entry 0, flags already set, load.
        e = 32'h3ABC_D123; v = 24'h012345;
        g = gbase(e, v, 0, BASE, MASK);
        put(g, mk_w0(1, v, 0, e), 32'h1234_5182);
        walk("primary hit no writeback", e, v, 0, BASE, MASK, 0);

        // R4 R7: decoys (invalid, wrong tag, wrong pass flag) then hit at entry 5.
        mem.delete();
        e = 32'h5F00_0ABC; v = 24'hA5A5A5;
        g = gbase(e, v, 0, BASE, MASK);
        put(g,      mk_w0(0, v, 0, e), 32'hFFFF_F000);
        put(g + 8,  mk_w0(1, v ^ 24'h1, 0, e), 32'hEEEE_E000);
        put(g + 16, mk_w0(1, v, 1, e), 32'hDDDD_D000);
        put(g + 24, mk_w0(1, v, 0, e ^ 32'h0040_0000), 32'hCCCC_C000);
        put(g + 40, mk_w0(1, v, 0, e), 32'h0BEE_F003);
        walk("decoys then referenced write", e, v, 0, BASE, MASK, 0);
        check("R7 referenced byte in memory", rd(g + 44), 32'h0BEE_F103);

        // R5 R8: primary full of non-matching entries, secondary hit, store.
        mem.delete();
        e = 32'h0123_4FFF; v = 24'h000777;
        g = gbase(e, v, 0, BASE, MASK); g2 = gbase(e, v, 1, BASE, MASK);
        for (int i = 0; i < 8; i++) put(g + 32'(i * 8), mk_w0(1, v, 1, e), 32'h1111_1000);
        put(g2 + 24, mk_w0(1, v, 1, e), 32'h7654_3002);
        walk("secondary hit store both writes", e, v, 1, BASE, MASK, 0);
        check("R8 both flag bytes in memory", rd(g2 + 28), 32'h7654_3182);

        // R8: store with referenced set, changed clear.
        mem.delete();
        e = 32'h9000_1004; v = 24'h0F0F0F;
        g = gbase(e, v, 0, BASE, MASK);
        put(g + 8, mk_w0(1, v, 0, e), 32'h2222_2101);
        walk("store changed only", e, v, 1, BASE, MASK, 0);

        // R8: load with changed clear must not set it.
        mem.delete();
        put(g + 8, mk_w0(1, v, 0, e), 32'h2222_2101);
        walk("load leaves changed clear", e, v, 0, BASE, MASK, 0);
        check("R8 changed byte untouched on load", rd(g + 12), 32'h2222_2101);

        // R7: store with changed already set, referenced clear.
        mem.delete();
        put(g + 56, mk_w0(1, v, 0, e), 32'h3333_3080);
        walk("store referenced only", e, v, 1, BASE, MASK, 0);

        // R2: small mask and different base, hit at last primary entry.
        mem.delete();
        e = 32'hFFFF_F7AB; v = 24'hFEDCBA;
        g = gbase(e, v, 0, 32'h0040_0000, 32'h0000_03C0);
        put(g + 56, mk_w0(1, v, 0, e), 32'h5555_5180);
        walk("masked table last entry", e, v, 0, 32'h0040_0000, 32'h0000_03C0, 0);

        // R9: empty table, full miss.
        mem.delete();
        walk("double miss", 32'h4444_4444, 24'h123456, 1, BASE, MASK, 0);

        // R10: second start during a walk is ignored.
        walk("start while busy", 32'h2468_ACE0, 24'h0AAAAA, 0, BASE, MASK, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule